// File: doc/BRIEF.md
# Indexed Video Register Port Decoder

This block sits between a byte-wide host I/O bus and the 8-bit configuration registers of a display controller. Most registers are reached indirectly. The host first writes a register number to one port. It then reads or writes the selected register through the port one address above it. A 16-bit write to the first port does both steps at once.

One group shares a single port for the number and the value. An internal phase bit decides which of the two the next write carries. Reading the input status port forces that bit back to the number phase, so software can always reach a known state.

A separate miscellaneous register is written and read at two different ports. Its least significant bit moves both the display-timing register pair and the status port between two address windows. Bit 7 of timing register 17 locks timing registers 0 to 7 against writes. Register contents are held here as plain per-index byte arrays. Timing generation is not part of this block.

Top module: `vio_port_decoder`

## Requirements
- R1: After reset, every register and index is zero, the shared-port phase is the number phase, and the miscellaneous register reads 0x00.
- R2: The three indexed pairs have their number port at 0x3C4, 0x3CE and the timing base. The value port is number port + 1. A read of a number port returns the stored index, and a read of a value port returns the selected register.
- R3: The index registers keep only their low bits: 3 bits for the 5 sequencing registers, 4 bits for the 9 graphics registers, and 5 bits for the 21 shared-port registers and for the 25 timing registers.
- R4: When a stored index is at or above its group's register count, its value port reads 0x00 and writes to it change nothing.
- R5: A write with `io_word` high at a number port stores `io_wdata[7:0]` as the index. In the same cycle it writes `io_wdata[15:8]` to the register that this new index selects. At every other port only `io_wdata[7:0]` is used.
- R6: Each write to 0x3C0 flips the phase. In the number phase the byte becomes the index. In the value phase it is written to the indexed register.
- R7: A read of 0x3C0 returns the shared-port index and a read of 0x3C1 returns the indexed register. Neither read changes the phase.
- R8: A read of the active status port returns 0x00 and forces the number phase.
- R9: The miscellaneous register is written at 0x3C2 and read at 0x3CC. A read of 0x3C2 returns 0xFF.
- R10: When miscellaneous bit 0 is 1, the timing pair sits at 0x3D4/0x3D5 and status at 0x3DA. When it is 0, they sit at 0x3B4/0x3B5 and 0x3BA. The inactive window reads 0xFF, ignores writes, and its status read leaves the phase unchanged.
- R11: While bit 7 of timing register 17 is 1, writes to timing registers 0 to 7 are ignored. This holds for word writes too. Timing registers 8 and above, including register 17, stay writable.
- R12: A read of any unmapped 16-bit address returns 0xFF. Reads and writes of unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address, fully decoded |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_word | input | 1 | Marks a write as 16 bits wide |
| io_wdata | input | 16 | Write data; the high byte is used only for word writes at number ports |
| io_rdata | output | 8 | Read data, combinational from the address and current state |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume that each cycle with a strobe is exactly one access. Reset must be held low across at least one clock edge, so that the first cycle after release can be checked against the cleared state. The bench drives one access per cycle on the falling edge, with the strobes mutually exclusive. It samples read data before the next rising edge, which keeps every stimulus within these assumptions.

// File: rtl/vio_pkg.sv
package vio_pkg;

    // Fixed port map; offsets matter because software addresses them directly
    localparam logic [15:0] ATT_PORT    = 16'h03C0;
    localparam logic [15:0] ATT_RD_PORT = 16'h03C1;
    localparam logic [15:0] MISC_WR     = 16'h03C2;
    localparam logic [15:0] SEQ_BASE    = 16'h03C4;
    localparam logic [15:0] MISC_RD     = 16'h03CC;
    localparam logic [15:0] GFX_BASE    = 16'h03CE;
    localparam logic [15:0] CRT_BASE_HI = 16'h03D4;
    localparam logic [15:0] CRT_BASE_LO = 16'h03B4;
    localparam logic [15:0] STAT_HI     = 16'h03DA;
    localparam logic [15:0] STAT_LO     = 16'h03BA;

    localparam logic [7:0] OPEN_BUS  = 8'hFF;
    localparam logic [7:0] STAT_BYTE = 8'h00;

    // Index width needed for a group of n registers
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // One-hot-ish port hit vector produced by the address decoder
    typedef struct packed {
        logic att_i;
        logic att_d;
        logic misc_w;
        logic misc_r;
        logic seq_i;
        logic seq_d;
        logic gfx_i;
        logic gfx_d;
        logic crt_i;
        logic crt_d;
        logic stat;
    } vio_hit_t;

endpackage

// File: rtl/vio_addr_decode.sv
module vio_addr_decode
    import vio_pkg::*;
(
    input  logic [15:0] addr,
    input  logic        crt_hi,
    output vio_hit_t    hit
);

    logic [15:0] crt_base;
    logic [15:0] stat_port;

    always_comb begin
        crt_base  = crt_hi ? CRT_BASE_HI : CRT_BASE_LO;
        stat_port = crt_hi ? STAT_HI : STAT_LO;

        hit        = '0;
        hit.att_i  = (addr == ATT_PORT);
        hit.att_d  = (addr == ATT_RD_PORT);
        hit.misc_w = (addr == MISC_WR);
        hit.misc_r = (addr == MISC_RD);
        hit.seq_i  = (addr == SEQ_BASE);
        hit.seq_d  = (addr == SEQ_BASE + 16'd1);
        hit.gfx_i  = (addr == GFX_BASE);
        hit.gfx_d  = (addr == GFX_BASE + 16'd1);
        hit.crt_i  = (addr == crt_base);
        hit.crt_d  = (addr == crt_base + 16'd1);
        hit.stat   = (addr == stat_port);
    end

endmodule

// File: rtl/vio_idx_group.sv
module vio_idx_group
    import vio_pkg::*;
#(
    parameter int  N        = 8,
    parameter bit  LOCK_EN  = 1'b0,
    parameter int  LOCK_N   = 0,
    parameter int  LOCK_IDX = 0,
    parameter int  LOCK_BIT = 0,
    localparam int IW       = idx_w(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_we,
    input  logic [IW-1:0] idx_val,
    input  logic          dat_we,
    input  logic [7:0]    dat_val,
    output logic [7:0]    idx_rd,
    output logic [7:0]    dat_rd
);

    typedef struct packed {
        logic [IW-1:0]     idx;
        logic [N-1:0][7:0] regs;
    } grp_st_t;

    grp_st_t       st_d;
    grp_st_t       st_q;
    logic [IW-1:0] tgt;
    logic          tgt_ok;
    logic          tgt_locked;
    logic          lock_bit;
    logic          cur_ok;

    // The lock bit lives in this group's own storage when enabled
    generate
        if (LOCK_EN && (LOCK_IDX < N)) begin : g_lock
            assign lock_bit = st_q.regs[LOCK_IDX][LOCK_BIT];
        end else begin : g_nolock
            assign lock_bit = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        // A word write forwards the fresh index to the data half
        tgt        = idx_we ? idx_val : st_q.idx;
        tgt_ok     = int'(tgt) < N;
        tgt_locked = lock_bit && (int'(tgt) < LOCK_N);
        if (idx_we) begin
            st_d.idx = idx_val;
        end
        if (dat_we && tgt_ok && !tgt_locked) begin
            st_d.regs[tgt] = dat_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cur_ok = int'(st_q.idx) < N;
        idx_rd = 8'(st_q.idx);
        dat_rd = cur_ok ? st_q.regs[st_q.idx] : 8'h00;
    end

endmodule

// File: rtl/vio_port_decoder.sv
module vio_port_decoder
    import vio_pkg::*;
#(
    parameter int SEQ_N        = 5,
    parameter int GFX_N        = 9,
    parameter int ATT_N        = 21,
    parameter int CRT_N        = 25,
    parameter int CRT_LOCK_N   = 8,
    parameter int CRT_LOCK_IDX = 17,
    parameter int CRT_LOCK_BIT = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic        io_word,
    input  logic [15:0] io_wdata,
    output logic [7:0]  io_rdata
);

    localparam int SEQ_W = idx_w(SEQ_N);
    localparam int GFX_W = idx_w(GFX_N);
    localparam int ATT_W = idx_w(ATT_N);
    localparam int CRT_W = idx_w(CRT_N);

    typedef struct packed {
        logic [7:0] misc;
        logic       att_dat;
    } top_st_t;

    top_st_t    st_d;
    top_st_t    st_q;
    vio_hit_t   hit;

    // Observation points for the bound checker
    logic [7:0] misc_r;
    logic       att_dat_r;

    logic       seq_idx_we, seq_dat_we, gfx_idx_we, gfx_dat_we;
    logic       crt_idx_we, crt_dat_we, att_idx_we, att_dat_we;
    logic [7:0] seq_dat_val, gfx_dat_val, crt_dat_val;
    logic [7:0] seq_idx_rd, seq_dat_rd, gfx_idx_rd, gfx_dat_rd;
    logic [7:0] crt_idx_rd, crt_dat_rd, att_idx_rd, att_dat_rd;

    vio_addr_decode u_dec (
        .addr   (io_addr),
        .crt_hi (st_q.misc[0]),
        .hit    (hit)
    );

    // Indexed pair strobes; a word write at a number port hits both halves
    assign seq_idx_we  = io_wr && hit.seq_i;
    assign seq_dat_we  = io_wr && (hit.seq_d || (hit.seq_i && io_word));
    assign seq_dat_val = hit.seq_i ? io_wdata[15:8] : io_wdata[7:0];

    assign gfx_idx_we  = io_wr && hit.gfx_i;
    assign gfx_dat_we  = io_wr && (hit.gfx_d || (hit.gfx_i && io_word));
    assign gfx_dat_val = hit.gfx_i ? io_wdata[15:8] : io_wdata[7:0];

    assign crt_idx_we  = io_wr && hit.crt_i;
    assign crt_dat_we  = io_wr && (hit.crt_d || (hit.crt_i && io_word));
    assign crt_dat_val = hit.crt_i ? io_wdata[15:8] : io_wdata[7:0];

    assign att_idx_we  = io_wr && hit.att_i && !st_q.att_dat;
    assign att_dat_we  = io_wr && hit.att_i && st_q.att_dat;

    vio_idx_group #(.N(SEQ_N)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_we  (seq_idx_we),
        .idx_val (io_wdata[SEQ_W-1:0]),
        .dat_we  (seq_dat_we),
        .dat_val (seq_dat_val),
        .idx_rd  (seq_idx_rd),
        .dat_rd  (seq_dat_rd)
    );

    vio_idx_group #(.N(GFX_N)) u_gfx (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_we  (gfx_idx_we),
        .idx_val (io_wdata[GFX_W-1:0]),
        .dat_we  (gfx_dat_we),
        .dat_val (gfx_dat_val),
        .idx_rd  (gfx_idx_rd),
        .dat_rd  (gfx_dat_rd)
    );

    vio_idx_group #(
        .N        (CRT_N),
        .LOCK_EN  (1'b1),
        .LOCK_N   (CRT_LOCK_N),
        .LOCK_IDX (CRT_LOCK_IDX),
        .LOCK_BIT (CRT_LOCK_BIT)
    ) u_crt (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_we  (crt_idx_we),
        .idx_val (io_wdata[CRT_W-1:0]),
        .dat_we  (crt_dat_we),
        .dat_val (crt_dat_val),
        .idx_rd  (crt_idx_rd),
        .dat_rd  (crt_dat_rd)
    );

    vio_idx_group #(.N(ATT_N)) u_att (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_we  (att_idx_we),
        .idx_val (io_wdata[ATT_W-1:0]),
        .dat_we  (att_dat_we),
        .dat_val (io_wdata[7:0]),
        .idx_rd  (att_idx_rd),
        .dat_rd  (att_dat_rd)
    );

    always_comb begin
        st_d = st_q;
        if (io_wr && hit.misc_w) begin
            st_d.misc = io_wdata[7:0];
        end
        if (io_wr && hit.att_i) begin
            st_d.att_dat = !st_q.att_dat;
        end
        // A status read wins; strobes are exclusive on a legal bus
        if (io_rd && hit.stat) begin
            st_d.att_dat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (hit.att_i)       io_rdata = att_idx_rd;
        else if (hit.att_d)  io_rdata = att_dat_rd;
        else if (hit.misc_r) io_rdata = st_q.misc;
        else if (hit.seq_i)  io_rdata = seq_idx_rd;
        else if (hit.seq_d)  io_rdata = seq_dat_rd;
        else if (hit.gfx_i)  io_rdata = gfx_idx_rd;
        else if (hit.gfx_d)  io_rdata = gfx_dat_rd;
        else if (hit.crt_i)  io_rdata = crt_idx_rd;
        else if (hit.crt_d)  io_rdata = crt_dat_rd;
        else if (hit.stat)   io_rdata = STAT_BYTE;
        else                 io_rdata = OPEN_BUS;
    end

    assign misc_r    = st_q.misc;
    assign att_dat_r = st_q.att_dat;

endmodule

// File: rtl/vio_port_decoder_chk.sv
module vio_port_decoder_chk
    import vio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [7:0]  wdata,
    input logic [7:0]  io_rdata,
    input logic [7:0]  misc_q,
    input logic        att_dat_q
);

    function automatic logic is_mapped(input logic [15:0] a, input logic hi);
        logic [15:0] cb;
        logic [15:0] sp;
        cb = hi ? CRT_BASE_HI : CRT_BASE_LO;
        sp = hi ? STAT_HI : STAT_LO;
        return (a == ATT_PORT) || (a == ATT_RD_PORT) || (a == MISC_RD) ||
               (a == SEQ_BASE) || (a == SEQ_BASE + 16'd1) ||
               (a == GFX_BASE) || (a == GFX_BASE + 16'd1) ||
               (a == cb) || (a == cb + 16'd1) || (a == sp);
    endfunction

    logic [15:0] stat_now;
    assign stat_now = misc_q[0] ? STAT_HI : STAT_LO;

    // input rule: one access per cycle
    bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (misc_q == 8'h00) && !att_dat_q);

    // R8
    status_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == stat_now) |=> !att_dat_q);

    // R6
    attr_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == ATT_PORT && !att_dat_q) |=> att_dat_q);

    // R6
    attr_to_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == ATT_PORT && att_dat_q) |=> !att_dat_q);

    // R9
    misc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == MISC_WR) |=> misc_q == $past(wdata));

    // R12
    unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !is_mapped(io_addr, misc_q[0])) |-> io_rdata == 8'hFF);

    // R12
    read_keeps_misc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> $stable(misc_q));

endmodule

bind vio_port_decoder vio_port_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .wdata     (io_wdata[7:0]),
    .io_rdata  (io_rdata),
    .misc_q    (misc_r),
    .att_dat_q (att_dat_r)
);

// File: tb/test_vio_port_decoder.sv
`timescale 1ns/1ps
module test_vio_port_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_word = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [7:0]  io_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int seq_r[5];
    int gfx_r[9];
    int att_r[21];
    int crt_r[25];
    int seq_i, gfx_i, att_i, crt_i;
    bit tog;
    int misc;

    always #2.5 clk = ~clk;

    vio_port_decoder i_vio_port_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_word  (io_word),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata)
    );

    function automatic int m_read(input int a);
        int cb = misc[0] ? 'h3D4 : 'h3B4;
        int sp = misc[0] ? 'h3DA : 'h3BA;
        if (a == 'h3C0) return att_i;
        if (a == 'h3C1) return (att_i < 21) ? att_r[att_i] : 0;
        if (a == 'h3CC) return misc;
        if (a == 'h3C4) return seq_i;
        if (a == 'h3C5) return (seq_i < 5) ? seq_r[seq_i] : 0;
        if (a == 'h3CE) return gfx_i;
        if (a == 'h3CF) return (gfx_i < 9) ? gfx_r[gfx_i] : 0;
        if (a == cb) return crt_i;
        if (a == cb + 1) return (crt_i < 25) ? crt_r[crt_i] : 0;
        if (a == sp) return 0;
        return 'hFF;
    endfunction

    function automatic void m_crt_data(input int v);
        bit locked = ((crt_r[17] >> 7) & 1) == 1 && crt_i < 8;
        if (crt_i < 25 && !locked) crt_r[crt_i] = v;
    endfunction

    function automatic void m_write(input int a, input int d, input bit wd);
        int cb = misc[0] ? 'h3D4 : 'h3B4;
        int lo = d & 'hFF;
        int hi = (d >> 8) & 'hFF;
        if (a == 'h3C0) begin
            if (!tog) att_i = lo & 31;
            else if (att_i < 21) att_r[att_i] = lo;
            tog = !tog;
        end else if (a == 'h3C2) begin
            misc = lo;
        end else if (a == 'h3C4) begin
            seq_i = lo & 7;
            if (wd && seq_i < 5) seq_r[seq_i] = hi;
        end else if (a == 'h3C5) begin
            if (seq_i < 5) seq_r[seq_i] = lo;
        end else if (a == 'h3CE) begin
            gfx_i = lo & 15;
            if (wd && gfx_i < 9) gfx_r[gfx_i] = hi;
        end else if (a == 'h3CF) begin
            if (gfx_i < 9) gfx_r[gfx_i] = lo;
        end else if (a == cb) begin
            crt_i = lo & 31;
            if (wd) m_crt_data(hi);
        end else if (a == cb + 1) begin
            m_crt_data(lo);
        end
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic op(input bit rd, input bit wr, input bit wd,
                      input int a, input int d, input string tag);
        @(negedge clk);
        io_addr  = 16'(a);
        io_rd    = rd;
        io_wr    = wr;
        io_word  = wd;
        io_wdata = 16'(d);
        #1;
        if (rd) chk(tag, int'(io_rdata), m_read(a));
        @(posedge clk);
        if (wr) m_write(a, d, wd);
        if (rd && a == (misc[0] ? 'h3DA : 'h3BA)) tog = 1'b0;
        #0.5;
        io_rd = 1'b0;
        io_wr = 1'b0;
        io_word = 1'b0;
    endtask

    task automatic wr8(input int a, input int d);
        op(1'b0, 1'b1, 1'b0, a, d, "");
    endtask

    task automatic wr16(input int a, input int d);
        op(1'b0, 1'b1, 1'b1, a, d, "");
    endtask

    task automatic rd(input int a, input string tag);
        op(1'b1, 1'b0, 1'b0, a, 0, tag);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        foreach (seq_r[k]) seq_r[k] = 0;
        foreach (gfx_r[k]) gfx_r[k] = 0;
        foreach (att_r[k]) att_r[k] = 0;
        foreach (crt_r[k]) crt_r[k] = 0;
        seq_i = 0; gfx_i = 0; att_i = 0; crt_i = 0; tog = 0; misc = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state; R10 timing pair in the low window
        rd('h3CC, "R1 misc");
        rd('h3B4, "R1 timing index");
        rd('h3C0, "R1 shared index");
        rd('h3C5, "R1 seq data");
        rd('h3D5, "R10 high window inactive");

        // R9 misc write/read ports
        wr8('h3C2, 'h67);
        rd('h3CC, "R9 misc readback");
        rd('h3C2, "R9 write port reads open");

        // R10 high window active, low window ignored; R2 timing pair
        rd('h3B4, "R10 low window inactive");
        wr8('h3D4, 'h0A);
        wr8('h3D5, 'h5C);
        rd('h3D5, "R2 timing data");
        wr8('h3B4, 'h03);
        wr8('h3B5, 'h99);
        rd('h3D4, "R10 inactive write ignored");

        // R2 sequencing and graphics pairs
        wr8('h3C4, 'h02);
        wr8('h3C5, 'hA1);
        wr8('h3CE, 'h08);
        wr8('h3CF, 'h3E);
        rd('h3C4, "R2 seq index");
        rd('h3C5, "R2 seq data");
        rd('h3CF, "R2 gfx data");

        // R3 truncation; R4 out-of-range
        wr8('h3C4, 'hFE);
        rd('h3C4, "R3 seq index width");
        wr8('h3C5, 'h77);
        rd('h3C5, "R4 seq out of range");
        wr8('h3CE, 'hFB);
        rd('h3CE, "R3 gfx index width");
        rd('h3CF, "R4 gfx out of range");
        wr8('h3C4, 'h02);
        rd('h3C5, "R4 stored value intact");

        // R5 word writes
        wr16('h3CE, 'h5503);
        rd('h3CE, "R5 gfx word index");
        rd('h3CF, "R5 gfx word data");
        wr16('h3D4, 'h4411);
        rd('h3D5, "R5 timing word data");
        wr16('h3C2, 'hAA67);
        rd('h3CC, "R5 low byte only elsewhere");

        // R11 protect
        wr8('h3D4, 'h02);
        wr8('h3D5, 'h12);
        rd('h3D5, "R11 unlocked write");
        wr16('h3D4, 'h8011);
        wr8('h3D4, 'h02);
        wr8('h3D5, 'hEE);
        rd('h3D5, "R11 locked byte write");
        wr16('h3D4, 'hEE07);
        rd('h3D5, "R11 locked word write");
        wr16('h3D4, 'h3309);
        rd('h3D5, "R11 upper register free");
        wr16('h3D4, 'h0011);
        wr16('h3D4, 'hEE02);
        rd('h3D5, "R11 unlock");

        // R6/R7 shared port
        rd('h3DA, "R8 status value");
        wr8('h3C0, 'h04);
        wr8('h3C0, 'h2A);
        rd('h3C0, "R7 shared index");
        rd('h3C1, "R6 shared data");
        wr8('h3C0, 'h10);
        rd('h3C0, "R7 read keeps phase");
        rd('h3C1, "R7 read keeps phase");
        wr8('h3C0, 'h3F);
        rd('h3C1, "R7 phase preserved over reads");

        // R8 status read rearms the phase
        wr8('h3C0, 'h05);
        rd('h3DA, "R8 status rearm");
        wr8('h3C0, 'h07);
        rd('h3C0, "R8 next write is index");

        // R10 inactive status leaves phase
        wr8('h3C0, 'h04);
        rd('h3BA, "R10 inactive status");
        wr8('h3C0, 'h66);
        rd('h3C1, "R10 phase kept");

        // R4 shared group out of range
        rd('h3DA, "R8 status value");
        wr8('h3C0, 'h1F);
        wr8('h3C0, 'h55);
        rd('h3C1, "R4 shared out of range");
        wr8('h3C0, 'h10);
        rd('h3C0, "R6 index after ignored data");

        // R10 back to the low window
        wr8('h3C2, 'h66);
        rd('h3D4, "R10 high window off");
        rd('h3B4, "R10 low window index");
        rd('h3B5, "R10 low window data");
        rd('h3DA, "R10 high status off");
        rd('h3BA, "R10 low status");

        // R12 unmapped
        rd('h0000, "R12 zero address");
        rd('h3C3, "R12 gap");
        rd('h13C4, "R12 full decode");
        wr8('h3C6, 'h01);
        wr8('h13C2, 'h01);
        rd('h3CC, "R12 unmapped write no effect");
        rd('h3C5, "R12 seq intact");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule